// File: doc/BRIEF.md
# RISC Instruction Decoder and Control

This block takes one 32-bit instruction word of a three-format load/store RISC machine and turns it, with no clock and no state, into everything the datapath needs for one step. It cuts the word into its fields and picks the destination register, which comes from a different field in each format. It widens the 16-bit immediate in the way the operation calls for. It also sets the write enable, the ALU operation and operand source, the memory strobes and access size, and the branch and jump selects.

The integer subset covered is add, sub, slt, addi, slti, andi, ori, lui, lw, sw, lb, sb, beq, bne, j, jal and jr. Every other encoding is flagged as illegal and produces no side effect. The ALU, register file, memory and next-PC logic sit outside the block and consume its outputs in the same cycle. The word is a plain control input with no handshake: the outputs follow it combinationally, so no back-pressure applies.

Top module: `insn_decoder`

## Requirements
- R1: `rs_idx_o` always equals instruction bits [25:21] and `rt_idx_o` always equals bits [20:16], whatever the opcode.
- R2: `dst_idx_o` is bits [15:11] for op 0 (register format), 31 for jal (op 3), and bits [20:16] for every other opcode.
- R3: `reg_we_o` is 1 for add, sub, slt, addi, slti, andi, ori, lui, lw, lb and jal, and 0 for sw, sb, beq, bne, j and jr.
- R4: When the selected destination index is 0, `reg_we_o` is 0.
- R5: `alu_op_o` encodes 0 add, 1 sub, 2 set-less-than, 3 and, 4 or, 5 upper-pass. Register-format funct 100000 gives 0, 100010 gives 1, 101010 gives 2. Opcodes 8 (addi) give 0, 10 (slti) 2, 12 (andi) 3, 13 (ori) 4 and 15 (lui) 5. Loads and stores give 0, beq and bne give 1.
- R6: `alu_imm_sel_o` is 1 for addi, slti, andi, ori, lui, lw, sw, lb and sb, and 0 for all other words.
- R7: `imm_o` is bits [15:0] zero-extended for andi and ori, bits [15:0] followed by 16 zero bits for lui, and bits [15:0] sign-extended for every other word.
- R8: Op 35 (lw) and op 32 (lb) raise `mem_rd_o`; op 43 (sw) and op 40 (sb) raise `mem_wr_o`. `mem_byte_o` is 1 only for lb and sb.
- R9: `branch_o` is 1 for beq (op 4), 2 for bne (op 5) and 0 otherwise.
- R10: `jump_o` is 1 for j (op 2) and jal (op 3), and 2 for register-format funct 001000 (jr). `link_o` is 1 only for jal. `jtarget_o` always equals bits [25:0].
- R11: Any opcode outside the list, any register-format funct other than 100000, 100010, 101010 and 001000, and any register-format word with a nonzero bits [10:6], raise `illegal_o`. In that case `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `link_o`, `branch_o` and `jump_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Instruction word to decode |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source register index |
| dst_idx_o | output | 5 | Destination register index |
| reg_we_o | output | 1 | Register file write enable |
| link_o | output | 1 | Write data is the return address (PC+4) |
| alu_op_o | output | 3 | ALU operation code |
| alu_imm_sel_o | output | 1 | Second ALU operand is the immediate |
| imm_o | output | 32 | Extended immediate |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| mem_byte_o | output | 1 | Memory access is one byte (else a word) |
| branch_o | output | 2 | Branch condition select |
| jump_o | output | 2 | Jump select: none, field target, register |
| jtarget_o | output | 26 | Jump target field |
| illegal_o | output | 1 | Word is not in the supported subset |

## Verification
Every output of this decoder is due in the same cycle as the word that produces it: no register lies between `instr_i` and any output. The bench therefore applies each word just after a falling clock edge and samples all outputs one nanosecond later, well before the next rising edge. Each vector is fully settled and checked before the next word is applied.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;
  localparam int WORD_W = 32;
  localparam int RIDX_W = 5;
  localparam int IMM_W  = 16;
  localparam int TGT_W  = 26;
  localparam int OP_W   = 6;
  localparam int FN_W   = 6;
  localparam int SH_W   = 5;
  localparam logic [RIDX_W-1:0] LINK_REG = RIDX_W'(31);

  localparam logic [OP_W-1:0] OP_REG  = 6'd0;
  localparam logic [OP_W-1:0] OP_J    = 6'd2;
  localparam logic [OP_W-1:0] OP_JAL  = 6'd3;
  localparam logic [OP_W-1:0] OP_BEQ  = 6'd4;
  localparam logic [OP_W-1:0] OP_BNE  = 6'd5;
  localparam logic [OP_W-1:0] OP_ADDI = 6'd8;
  localparam logic [OP_W-1:0] OP_SLTI = 6'd10;
  localparam logic [OP_W-1:0] OP_ANDI = 6'd12;
  localparam logic [OP_W-1:0] OP_ORI  = 6'd13;
  localparam logic [OP_W-1:0] OP_LUI  = 6'd15;
  localparam logic [OP_W-1:0] OP_LB   = 6'd32;
  localparam logic [OP_W-1:0] OP_LW   = 6'd35;
  localparam logic [OP_W-1:0] OP_SB   = 6'd40;
  localparam logic [OP_W-1:0] OP_SW   = 6'd43;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;
  localparam logic [FN_W-1:0] FN_JR  = 6'b001000;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_SLT = 3'd2,
    ALU_AND = 3'd3, ALU_OR = 3'd4, ALU_UPPER = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2} br_e;
  typedef enum logic [1:0] {JMP_NONE = 2'd0, JMP_TGT = 2'd1, JMP_REG = 2'd2} jmp_e;
  typedef enum logic [1:0] {EXT_SIGN = 2'd0, EXT_ZERO = 2'd1, EXT_UPPER = 2'd2} ext_e;
  typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;

  typedef struct packed {
    logic    we;
    logic    link;
    alu_op_e alu;
    logic    imm_sel;
    ext_e    ext;
    dst_e    dst;
    logic    mrd;
    logic    mwr;
    logic    mbyte;
    br_e     br;
    jmp_e    jmp;
    logic    ill;
  } ctrl_t;
endpackage

// File: rtl/insn_field_split.sv
module insn_field_split
  import insn_dec_pkg::*;
(
  input  logic [WORD_W-1:0] word_i,
  output logic [OP_W-1:0]   op_o,
  output logic [RIDX_W-1:0] rs_o,
  output logic [RIDX_W-1:0] rt_o,
  output logic [RIDX_W-1:0] rd_o,
  output logic              sh_nz_o,
  output logic [FN_W-1:0]   fn_o,
  output logic [IMM_W-1:0]  imm_o,
  output logic [TGT_W-1:0]  tgt_o
);
  localparam int OP_LO = WORD_W - OP_W;
  localparam int RS_LO = OP_LO - RIDX_W;
  localparam int RT_LO = RS_LO - RIDX_W;
  localparam int RD_LO = RT_LO - RIDX_W;
  localparam int SH_LO = RD_LO - SH_W;

  assign op_o    = word_i[WORD_W-1:OP_LO];
  assign rs_o    = word_i[OP_LO-1:RS_LO];
  assign rt_o    = word_i[RS_LO-1:RT_LO];
  assign rd_o    = word_i[RT_LO-1:RD_LO];
  assign sh_nz_o = |word_i[RD_LO-1:SH_LO];
  assign fn_o    = word_i[FN_W-1:0];
  assign imm_o   = word_i[IMM_W-1:0];
  assign tgt_o   = word_i[TGT_W-1:0];
endmodule

// File: rtl/insn_ctrl_decode.sv
module insn_ctrl_decode
  import insn_dec_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic            sh_nz_i,
  output ctrl_t           ctrl_o
);
  ctrl_t c;

  always_comb begin
    c         = '0;
    c.alu     = ALU_ADD;
    c.ext     = EXT_SIGN;
    c.dst     = DST_RT;
    c.br      = BR_NONE;
    c.jmp     = JMP_NONE;
    case (op_i)
      OP_REG: begin
        c.dst = DST_RD;
        if (sh_nz_i) c.ill = 1'b1;
        else begin
          case (fn_i)
            FN_ADD:  c.we = 1'b1;
            FN_SUB:  begin c.we = 1'b1; c.alu = ALU_SUB; end
            FN_SLT:  begin c.we = 1'b1; c.alu = ALU_SLT; end
            FN_JR:   c.jmp = JMP_REG;
            default: c.ill = 1'b1;
          endcase
        end
      end
      OP_ADDI: begin c.we = 1'b1; c.imm_sel = 1'b1; end
      OP_SLTI: begin c.we = 1'b1; c.imm_sel = 1'b1; c.alu = ALU_SLT; end
      OP_ANDI: begin c.we = 1'b1; c.imm_sel = 1'b1; c.alu = ALU_AND; c.ext = EXT_ZERO; end
      OP_ORI:  begin c.we = 1'b1; c.imm_sel = 1'b1; c.alu = ALU_OR;  c.ext = EXT_ZERO; end
      OP_LUI:  begin c.we = 1'b1; c.imm_sel = 1'b1; c.alu = ALU_UPPER; c.ext = EXT_UPPER; end
      OP_LW:   begin c.we = 1'b1; c.imm_sel = 1'b1; c.mrd = 1'b1; end
      OP_LB:   begin c.we = 1'b1; c.imm_sel = 1'b1; c.mrd = 1'b1; c.mbyte = 1'b1; end
      OP_SW:   begin c.imm_sel = 1'b1; c.mwr = 1'b1; end
      OP_SB:   begin c.imm_sel = 1'b1; c.mwr = 1'b1; c.mbyte = 1'b1; end
      OP_BEQ:  begin c.alu = ALU_SUB; c.br = BR_EQ; end
      OP_BNE:  begin c.alu = ALU_SUB; c.br = BR_NE; end
      OP_J:    c.jmp = JMP_TGT;
      OP_JAL:  begin c.jmp = JMP_TGT; c.we = 1'b1; c.link = 1'b1; c.dst = DST_LINK; end
      default: c.ill = 1'b1;
    endcase
    if (c.ill) begin
      c.we   = 1'b0;
      c.link = 1'b0;
      c.mrd  = 1'b0;
      c.mwr  = 1'b0;
      c.br   = BR_NONE;
      c.jmp  = JMP_NONE;
    end
  end

  assign ctrl_o = c;
endmodule

// File: rtl/insn_imm_ext.sv
module insn_imm_ext
  import insn_dec_pkg::*;
#(
  parameter int IN_W  = IMM_W,
  parameter int OUT_W = WORD_W
) (
  input  logic [IN_W-1:0]  raw_i,
  input  ext_e             mode_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int PAD_W = OUT_W - IN_W;

  always_comb begin
    case (mode_i)
      EXT_ZERO:  ext_o = {{PAD_W{1'b0}}, raw_i};
      EXT_UPPER: ext_o = {raw_i, {PAD_W{1'b0}}};
      default:   ext_o = {{PAD_W{raw_i[IN_W-1]}}, raw_i};
    endcase
  end
endmodule

// File: rtl/insn_decoder.sv
module insn_decoder
  import insn_dec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rs_idx_o,
  output logic [4:0]  rt_idx_o,
  output logic [4:0]  dst_idx_o,
  output logic        reg_we_o,
  output logic        link_o,
  output logic [2:0]  alu_op_o,
  output logic        alu_imm_sel_o,
  output logic [31:0] imm_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        mem_byte_o,
  output logic [1:0]  branch_o,
  output logic [1:0]  jump_o,
  output logic [25:0] jtarget_o,
  output logic        illegal_o
);
  logic [OP_W-1:0]   op;
  logic [RIDX_W-1:0] rs, rt, rd, dst;
  logic              sh_nz;
  logic [FN_W-1:0]   fn;
  logic [IMM_W-1:0]  imm16;
  ctrl_t             ctrl;

  insn_field_split u_split (
    .word_i(instr_i), .op_o(op), .rs_o(rs), .rt_o(rt), .rd_o(rd),
    .sh_nz_o(sh_nz), .fn_o(fn), .imm_o(imm16), .tgt_o(jtarget_o)
  );

  insn_ctrl_decode u_ctrl (
    .op_i(op), .fn_i(fn), .sh_nz_i(sh_nz), .ctrl_o(ctrl)
  );

  insn_imm_ext #(.IN_W(IMM_W), .OUT_W(WORD_W)) u_imm (
    .raw_i(imm16), .mode_i(ctrl.ext), .ext_o(imm_o)
  );

  always_comb begin
    case (ctrl.dst)
      DST_RD:   dst = rd;
      DST_LINK: dst = LINK_REG;
      default:  dst = rt;
    endcase
  end

  assign rs_idx_o      = rs;
  assign rt_idx_o      = rt;
  assign dst_idx_o     = dst;
  assign reg_we_o      = ctrl.we && (dst != '0);
  assign link_o        = ctrl.link;
  assign alu_op_o      = ctrl.alu;
  assign alu_imm_sel_o = ctrl.imm_sel;
  assign mem_rd_o      = ctrl.mrd;
  assign mem_wr_o      = ctrl.mwr;
  assign mem_byte_o    = ctrl.mbyte;
  assign branch_o      = ctrl.br;
  assign jump_o        = ctrl.jmp;
  assign illegal_o     = ctrl.ill;
endmodule

// File: rtl/insn_decoder_chk.sv
module insn_decoder_chk (
  input logic [31:0] instr_i,
  input logic [4:0]  rs_idx_o,
  input logic [4:0]  dst_idx_o,
  input logic        reg_we_o,
  input logic        link_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic        mem_byte_o,
  input logic [1:0]  branch_o,
  input logic [1:0]  jump_o,
  input logic        illegal_o
);
  always_comb begin
    a_r1_rs_field: assert (rs_idx_o == instr_i[25:21])
      else $error("rs index does not track word");
    a_r4_no_zero_write: assert (!(reg_we_o && dst_idx_o == 5'd0))
      else $error("write to register zero");
    a_r3_store_no_write: assert (!(mem_wr_o && reg_we_o))
      else $error("store also writes a register");
    a_r3_branch_no_write: assert (!(branch_o != 2'd0 && reg_we_o))
      else $error("branch also writes a register");
    a_r8_one_strobe: assert (!(mem_rd_o && mem_wr_o))
      else $error("read and write strobes together");
    a_r8_byte_needs_access: assert (!mem_byte_o || mem_rd_o || mem_wr_o)
      else $error("byte size without access");
    a_r10_link_is_r31: assert (!link_o || (reg_we_o && dst_idx_o == 5'd31 && jump_o == 2'd1))
      else $error("link without write to r31");
    a_r11_illegal_quiet: assert (!illegal_o ||
        (!reg_we_o && !mem_rd_o && !mem_wr_o && !link_o && branch_o == 2'd0 && jump_o == 2'd0))
      else $error("illegal word has side effects");
  end
endmodule

bind insn_decoder insn_decoder_chk u_chk (
  .instr_i(instr_i), .rs_idx_o(rs_idx_o), .dst_idx_o(dst_idx_o),
  .reg_we_o(reg_we_o), .link_o(link_o), .mem_rd_o(mem_rd_o),
  .mem_wr_o(mem_wr_o), .mem_byte_o(mem_byte_o), .branch_o(branch_o),
  .jump_o(jump_o), .illegal_o(illegal_o)
);

// File: tb/tb_insn_decoder.sv
module tb_insn_decoder;
  logic        clk = 1'b0;
  logic [31:0] instr_i;
  logic [4:0]  rs_idx_o, rt_idx_o, dst_idx_o;
  logic        reg_we_o, link_o, alu_imm_sel_o, mem_rd_o, mem_wr_o, mem_byte_o, illegal_o;
  logic [2:0]  alu_op_o;
  logic [31:0] imm_o;
  logic [1:0]  branch_o, jump_o;
  logic [25:0] jtarget_o;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  insn_decoder dut (
    .instr_i(instr_i), .rs_idx_o(rs_idx_o), .rt_idx_o(rt_idx_o),
    .dst_idx_o(dst_idx_o), .reg_we_o(reg_we_o), .link_o(link_o),
    .alu_op_o(alu_op_o), .alu_imm_sel_o(alu_imm_sel_o), .imm_o(imm_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_byte_o(mem_byte_o),
    .branch_o(branch_o), .jump_o(jump_o), .jtarget_o(jtarget_o),
    .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [31:0] instr;
    logic [4:0]  dst;
    logic        we;
    logic [2:0]  alu;
    logic        sel;
    logic [31:0] imm;
    logic        mrd;
    logic        mwr;
    logic        mbyte;
    logic [1:0]  br;
    logic [1:0]  jmp;
    logic        ill;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{32'h02324020, 5'd8,  1'b1, 3'd0, 1'b0, 32'h00004020, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h014B4822, 5'd9,  1'b1, 3'd1, 1'b0, 32'h00004822, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h0128502A, 5'd10, 1'b1, 3'd2, 1'b0, 32'h0000502A, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h23BDFFFC, 5'd29, 1'b1, 3'd0, 1'b1, 32'hFFFFFFFC, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h2A48000A, 5'd8,  1'b1, 3'd2, 1'b1, 32'h0000000A, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h33BD8006, 5'd29, 1'b1, 3'd3, 1'b1, 32'h00008006, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h3508AAAA, 5'd8,  1'b1, 3'd4, 1'b1, 32'h0000AAAA, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h3C08AAAA, 5'd8,  1'b1, 3'd5, 1'b1, 32'hAAAA0000, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h8E680020, 5'd8,  1'b1, 3'd0, 1'b1, 32'h00000020, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'hAE688000, 5'd8,  1'b0, 3'd0, 1'b1, 32'hFFFF8000, 1'b0, 1'b1, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h8089FFFF, 5'd9,  1'b1, 3'd0, 1'b1, 32'hFFFFFFFF, 1'b1, 1'b0, 1'b1, 2'd0, 2'd0, 1'b0},
    '{32'hA0890005, 5'd9,  1'b0, 3'd0, 1'b1, 32'h00000005, 1'b0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0},
    '{32'h1295FFFE, 5'd21, 1'b0, 3'd1, 1'b0, 32'hFFFFFFFE, 1'b0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0},
    '{32'h15000003, 5'd0,  1'b0, 3'd1, 1'b0, 32'h00000003, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 1'b0},
    '{32'h080009C4, 5'd0,  1'b0, 3'd0, 1'b0, 32'h000009C4, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0},
    '{32'h0C0009C4, 5'd31, 1'b1, 3'd0, 1'b0, 32'h000009C4, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 1'b0},
    '{32'h03E00008, 5'd0,  1'b0, 3'd0, 1'b0, 32'h00000008, 1'b0, 1'b0, 1'b0, 2'd0, 2'd2, 1'b0},
    '{32'hFD2A1234, 5'd10, 1'b0, 3'd0, 1'b0, 32'h00001234, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
    '{32'h02324027, 5'd8,  1'b0, 3'd0, 1'b0, 32'h00004027, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b1},
    '{32'h02320020, 5'd0,  1'b0, 3'd0, 1'b0, 32'h00000020, 1'b0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0},
    '{32'h8E600020, 5'd0,  1'b0, 3'd0, 1'b1, 32'h00000020, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0}
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s word=%h actual=%h expected=%h", req, what, instr_i, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr_i = w;
    #1;
  endtask

  initial begin
    instr_i = 32'h0;
    #1;
    // Initial all-zero word: register format, funct 0, unsupported (R11)
    chk("R11", "illegal", 32'(illegal_o), 32'd1);
    chk("R11", "we", 32'(reg_we_o), 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].instr);
      chk("R1",  "rs",   32'(rs_idx_o), 32'(VEC[i].instr[25:21]));
      chk("R1",  "rt",   32'(rt_idx_o), 32'(VEC[i].instr[20:16]));
      chk("R2",  "dst",  32'(dst_idx_o), 32'(VEC[i].dst));
      chk("R3",  "we",   32'(reg_we_o), 32'(VEC[i].we));
      chk("R5",  "alu",  32'(alu_op_o), 32'(VEC[i].alu));
      chk("R6",  "sel",  32'(alu_imm_sel_o), 32'(VEC[i].sel));
      chk("R7",  "imm",  imm_o, VEC[i].imm);
      chk("R8",  "rd",   32'(mem_rd_o), 32'(VEC[i].mrd));
      chk("R8",  "wr",   32'(mem_wr_o), 32'(VEC[i].mwr));
      chk("R8",  "byte", 32'(mem_byte_o), 32'(VEC[i].mbyte));
      chk("R9",  "br",   32'(branch_o), 32'(VEC[i].br));
      chk("R10", "jmp",  32'(jump_o), 32'(VEC[i].jmp));
      chk("R10", "tgt",  32'(jtarget_o), 32'(VEC[i].instr[25:0]));
      chk("R11", "ill",  32'(illegal_o), 32'(VEC[i].ill));
    end

    // R10: link only for jal, full 26-bit target passes through
    apply(32'h0FFFFFFF);
    chk("R10", "link jal", 32'(link_o), 32'd1);
    chk("R10", "tgt max", 32'(jtarget_o), 32'h03FFFFFF);
    chk("R2",  "jal dst", 32'(dst_idx_o), 32'd31);
    apply(32'h03E00008);
    chk("R10", "link jr", 32'(link_o), 32'd0);

    // R4: add and addi naming register zero are not written
    apply(32'h20000005);
    chk("R4", "addi r0 we", 32'(reg_we_o), 32'd0);
    chk("R4", "addi r0 ill", 32'(illegal_o), 32'd0);

    // R11: nonzero shift field on add is illegal and silent
    apply(32'h02324060);
    chk("R11", "shamt ill", 32'(illegal_o), 32'd1);
    chk("R11", "shamt we", 32'(reg_we_o), 32'd0);
    // R11: illegal opcode whose field pattern resembles a store
    apply(32'hBE688000);
    chk("R11", "op47 ill", 32'(illegal_o), 32'd1);
    chk("R11", "op47 wr", 32'(mem_wr_o), 32'd0);
    chk("R11", "op47 jmp", 32'(jump_o), 32'd0);

    // R7: sign boundary, 0x7FFF stays positive for slti
    apply(32'h2A487FFF);
    chk("R7", "slti 7fff", imm_o, 32'h00007FFF);
    // R7: ori with top bit set is zero-extended
    apply(32'h3508FFFF);
    chk("R7", "ori ffff", imm_o, 32'h0000FFFF);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule